// File: doc/BRIEF.md
# Multi-drop JTAG address selector

This block lets many identical test-access devices share one IEEE 1149.1 bus on a backplane. Each device has a 6-bit slot code strapped on its pins. It comes out of reset released from the bus, with its TDO output enable low. A host claims a device with an ordinary instruction scan. When the TAP passes Update-IR, the low six bits of the instruction register are compared against the slot code. One code selects every device, and four codes select the devices whose group register holds a matching value.

Only a device claimed on its own slot code drives TDO. In broadcast and group modes the devices listen, and their output enable stays low. A device that does not match stays deaf until it is sent back to waiting, or until it is reset. The block has a 16-state TAP controller, an 8-bit instruction register, the selection state machine, a 2-bit group register and a 1-bit bypass register. TDO is updated on the falling edge of TCK.

Top module: `jtsel_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, the device is waiting: `sel_n`=1, `en_n`=1 and `tdo_oe`=0.
- R2: On the TCK edge that leaves Update-IR in the waiting state, IR[5:0] values 0x00..0x3A that equal `slot_addr` select the device singly. IR[7:6] are ignored. `sel_n` and `en_n` go low after that edge. A slot value of 0x3B or above is never selected as a single address.
- R3: Any other code at that point, including a group code that does not match, makes the device ignoring. It then stays unselected through later address scans until GOTOWAIT, `rst`, `lrst_n` or Test-Logic-Reset.
- R4: Instruction 0xC3 loaded while selected or ignoring returns the device to waiting, so `sel_n` goes high.
- R5: Code 0x3B selects every waiting device; `tdo_oe` stays 0 in this mode.
- R6: Codes 0x3C..0x3F select the device only when its group register equals code-0x3C; `tdo_oe` stays 0 in this mode.
- R7: Instruction 0x03 connects the 2-bit group register. Capture-DR loads its value, and the bits shift LSB first from `tdi` toward `tdo`. Update-DR writes it while the device is selected. It resets to 0 on `rst` and in Test-Logic-Reset, and is kept across `lrst_n`.
- R8: Holding `tms` high for five TCK cycles reaches Test-Logic-Reset and returns the device to waiting.
- R9: `lrst_n` low at a rising TCK edge returns the device to waiting.
- R10: `tdo_oe` is high only in Shift-IR or Shift-DR while singly selected. `tdo` changes on the falling TCK edge. Capture-IR loads 0x01, which shifts out LSB first.
- R11: Any selected instruction other than 0x03 and 0xC3 connects a 1-bit bypass register that captures 0.
- R12: While the device is not selected, the instruction register still captures and shifts, so `tdo` carries 0x01 during Shift-IR. `tdo_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (test reset / power-up) |
| lrst_n | input | 1 | Synchronous active-low local return to waiting |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| slot_addr | input | 6 | Strapped slot code |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for tdo |
| sel_n | output | 1 | Low while the device is selected |
| en_n | output | 1 | Low while the device is selected |

## Verification
Address scans are issued in three kinds. Codes equal to the slot code test the single match, and the scans that follow on TDO tell single selection apart from broadcast or group selection. Codes in the top five values are sent against group registers that were written beforehand, so a matching group is told apart from a group that does not match. Random codes, slot values and groups are mixed with directed sequences: a mismatch followed by the correct code shows that the ignoring state holds. GOTOWAIT, the local reset and the five-TMS reset are each checked against the group register, to show which of them clear it.

// File: rtl/jtsel_pkg.sv
package jtsel_pkg;
    localparam int IR_W   = 8;
    localparam int ADDR_W = 6;
    localparam int GRP_W  = 2;
    localparam int NGRP   = 1 << GRP_W;

    localparam logic [ADDR_W-1:0] CODE_ALL   = ADDR_W'((1 << ADDR_W) - NGRP - 1);
    localparam logic [ADDR_W-1:0] CODE_GRP0  = ADDR_W'((1 << ADDR_W) - NGRP);
    localparam logic [ADDR_W-1:0] SINGLE_MAX = ADDR_W'((1 << ADDR_W) - NGRP - 2);

    localparam logic [IR_W-1:0] OP_GOTOWAIT = 8'hC3;
    localparam logic [IR_W-1:0] OP_GRPSEL   = 8'h03;
    localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 8'h01;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SEL_DR, T_CAP_DR, T_SH_DR, T_EX1_DR, T_PA_DR, T_EX2_DR,
        T_UPD_DR, T_SEL_IR, T_CAP_IR, T_SH_IR, T_EX1_IR, T_PA_IR, T_EX2_IR, T_UPD_IR
    } tap_st_t;

    typedef enum logic [1:0] {SL_WAIT, SL_ACTIVE, SL_IGNORED} sel_st_t;
    typedef enum logic [1:0] {MD_NONE, MD_SINGLE, MD_ALL, MD_GROUP} sel_md_t;

    typedef struct packed {
        sel_st_t          st;
        sel_md_t          md;
        logic [IR_W-1:0]  instr;
    } sel_ctx_t;

    function automatic tap_st_t tap_next(tap_st_t s, logic m);
        case (s)
            T_TLR:    return m ? T_TLR    : T_RTI;
            T_RTI:    return m ? T_SEL_DR : T_RTI;
            T_SEL_DR: return m ? T_SEL_IR : T_CAP_DR;
            T_CAP_DR: return m ? T_EX1_DR : T_SH_DR;
            T_SH_DR:  return m ? T_EX1_DR : T_SH_DR;
            T_EX1_DR: return m ? T_UPD_DR : T_PA_DR;
            T_PA_DR:  return m ? T_EX2_DR : T_PA_DR;
            T_EX2_DR: return m ? T_UPD_DR : T_SH_DR;
            T_UPD_DR: return m ? T_SEL_DR : T_RTI;
            T_SEL_IR: return m ? T_TLR    : T_CAP_IR;
            T_CAP_IR: return m ? T_EX1_IR : T_SH_IR;
            T_SH_IR:  return m ? T_EX1_IR : T_SH_IR;
            T_EX1_IR: return m ? T_UPD_IR : T_PA_IR;
            T_PA_IR:  return m ? T_EX2_IR : T_PA_IR;
            T_EX2_IR: return m ? T_UPD_IR : T_SH_IR;
            default:  return m ? T_SEL_DR : T_RTI;
        endcase
    endfunction

    // How a scanned code claims this device, MD_NONE when it does not.
    function automatic sel_md_t claim_kind(logic [ADDR_W-1:0] code,
                                           logic [ADDR_W-1:0] slot,
                                           logic [GRP_W-1:0]  grp);
        if (code <= SINGLE_MAX)
            return (code == slot) ? MD_SINGLE : MD_NONE;
        else if (code == CODE_ALL)
            return MD_ALL;
        else if (GRP_W'(code - CODE_GRP0) == grp)
            return MD_GROUP;
        else
            return MD_NONE;
    endfunction
endpackage

// File: rtl/jtsel_tap.sv
module jtsel_tap
    import jtsel_pkg::*;
(
    input  logic    tck,
    input  logic    rst,
    input  logic    tms,
    output tap_st_t state
);
    always_ff @(posedge tck) begin
        if (rst) state <= T_TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/jtsel_ir.sv
module jtsel_ir
    import jtsel_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         rst,
    input  tap_st_t      state,
    input  logic         tdi,
    output logic [W-1:0] ir_sr
);
    localparam logic [W-1:0] CAP = W'(IR_CAPTURE);

    always_ff @(posedge tck) begin
        if (rst)                    ir_sr <= CAP;
        else if (state == T_CAP_IR) ir_sr <= CAP;
        else if (state == T_SH_IR)  ir_sr <= {tdi, ir_sr[W-1:1]};
    end
endmodule

// File: rtl/jtsel_dr.sv
module jtsel_dr
    import jtsel_pkg::*;
#(
    parameter int GW = GRP_W
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_st_t         state,
    input  logic            tdi,
    input  logic [IR_W-1:0] instr,
    input  logic            selected,
    output logic [GW-1:0]   grp,
    output logic            dr_out
);
    logic [GW-1:0] grp_sr;
    logic          byp;
    logic          use_grp;

    assign use_grp = (instr == OP_GRPSEL);
    assign dr_out  = use_grp ? grp_sr[0] : byp;

    always_ff @(posedge tck) begin
        if (rst) begin
            grp_sr <= '0;
            byp    <= 1'b0;
        end else if (state == T_CAP_DR) begin
            grp_sr <= grp;
            byp    <= 1'b0;
        end else if (state == T_SH_DR) begin
            grp_sr <= {tdi, grp_sr[GW-1:1]};
            byp    <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (rst || state == T_TLR)
            grp <= '0;
        else if (state == T_UPD_DR && selected && use_grp)
            grp <= grp_sr;
    end

    AST_GRP_TLR: assert property (@(posedge tck) disable iff (rst)
        (state == T_TLR) |=> (grp == '0)); // R7
    AST_GRP_STABLE: assert property (@(posedge tck) disable iff (rst)
        (state != T_UPD_DR && state != T_TLR) |=> $stable(grp)); // R7
endmodule

// File: rtl/jtsel_sel.sv
module jtsel_sel
    import jtsel_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              lrst_n,
    input  tap_st_t           state,
    input  logic [IR_W-1:0]   ir_sr,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [GRP_W-1:0]  grp,
    output sel_ctx_t          ctx
);
    localparam sel_ctx_t CTX_IDLE = '{st: SL_WAIT, md: MD_NONE, instr: OP_BYPASS};

    sel_md_t claim;
    logic    goto_wait;

    assign claim     = claim_kind(ir_sr[ADDR_W-1:0], slot_addr, grp);
    assign goto_wait = (ir_sr == OP_GOTOWAIT);

    always_ff @(posedge tck) begin
        if (rst || !lrst_n || state == T_TLR) begin
            ctx <= CTX_IDLE;
        end else if (state == T_UPD_IR) begin
            case (ctx.st)
                SL_WAIT: begin
                    ctx.md    <= claim;
                    ctx.st    <= (claim == MD_NONE) ? SL_IGNORED : SL_ACTIVE;
                    ctx.instr <= OP_BYPASS;
                end
                SL_ACTIVE: begin
                    if (goto_wait) ctx <= CTX_IDLE;
                    else           ctx.instr <= ir_sr;
                end
                default: begin
                    if (goto_wait) ctx <= CTX_IDLE;
                end
            endcase
        end
    end

    AST_TLR_WAIT: assert property (@(posedge tck) disable iff (rst)
        (state == T_TLR) |=> (ctx.st == SL_WAIT)); // R8
    AST_LRST_WAIT: assert property (@(posedge tck) disable iff (rst)
        !lrst_n |=> (ctx.st == SL_WAIT)); // R9
    AST_GOTO_WAIT: assert property (@(posedge tck) disable iff (rst)
        (state == T_UPD_IR && ir_sr == OP_GOTOWAIT && ctx.st != SL_WAIT) |=> (ctx.st == SL_WAIT)); // R4
    AST_IGNORE_HOLD: assert property (@(posedge tck) disable iff (rst)
        (ctx.st == SL_IGNORED && lrst_n && state != T_TLR &&
         !(state == T_UPD_IR && ir_sr == OP_GOTOWAIT)) |=> (ctx.st == SL_IGNORED)); // R3
    AST_CLAIM_AT_UPDIR: assert property (@(posedge tck) disable iff (rst)
        (ctx.st == SL_WAIT && state != T_UPD_IR) |=> (ctx.st == SL_WAIT)); // R2
endmodule

// File: rtl/jtsel_top.sv
module jtsel_top
    import jtsel_pkg::*;
(
    input  logic              tck,
    input  logic              rst,
    input  logic              lrst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              sel_n,
    output logic              en_n
);
    tap_st_t           state;
    logic [IR_W-1:0]   ir_sr;
    logic [GRP_W-1:0]  grp;
    logic              dr_out;
    sel_ctx_t          ctx;
    logic              selected;
    logic              single;

    assign selected = (ctx.st == SL_ACTIVE);
    assign single   = selected && (ctx.md == MD_SINGLE);
    assign sel_n    = !selected;
    assign en_n     = !selected;

    jtsel_tap u_tap (.tck(tck), .rst(rst), .tms(tms), .state(state));

    jtsel_ir #(.W(IR_W)) u_ir (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi), .ir_sr(ir_sr));

    jtsel_sel u_sel (
        .tck(tck), .rst(rst), .lrst_n(lrst_n), .state(state), .ir_sr(ir_sr),
        .slot_addr(slot_addr), .grp(grp), .ctx(ctx));

    jtsel_dr #(.GW(GRP_W)) u_dr (
        .tck(tck), .rst(rst), .state(state), .tdi(tdi), .instr(ctx.instr),
        .selected(selected), .grp(grp), .dr_out(dr_out));

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == T_SH_IR) ? ir_sr[0] : dr_out;
            tdo_oe <= (state == T_SH_IR || state == T_SH_DR) && single;
        end
    end

    AST_OE_SINGLE: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (ctx.st == SL_ACTIVE && ctx.md == MD_SINGLE)); // R10
    AST_OE_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (state == T_SH_IR || state == T_SH_DR ||
                    state == T_EX1_IR || state == T_EX1_DR)); // R10
endmodule

// File: tb/jtsel_top_tb.sv
module jtsel_top_tb;
    logic       tck = 1'b0;
    logic       rst = 1'b1;
    logic       lrst_n = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic [5:0] slot_addr = 6'd5;
    logic       tdo, tdo_oe, sel_n, en_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] last_out;
    logic       last_oe;

    always #5 tck = ~tck;

    jtsel_top u_dut (
        .tck(tck), .rst(rst), .lrst_n(lrst_n), .tms(tms), .tdi(tdi),
        .slot_addr(slot_addr), .tdo(tdo), .tdo_oe(tdo_oe), .sel_n(sel_n), .en_n(en_n));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Drive, clock, then sample after the falling edge.
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #7;
    endtask

    task automatic do_rst();
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        rst = 1'b0;
        step(0, 0);
    endtask

    task automatic scan_ir(input logic [7:0] v);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        last_oe = tdo_oe;
        last_out[0] = tdo;
        for (int i = 0; i < 8; i++) begin
            step(i == 7, v[i]);
            if (i < 7) last_out[i+1] = tdo;
        end
        step(1, 0);
        step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [7:0] v);
        step(1, 0); step(0, 0); step(0, 0);
        last_oe = tdo_oe;
        last_out = '0;
        last_out[0] = tdo;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, v[i]);
            if (i < n - 1) last_out[i+1] = tdo;
        end
        step(1, 0);
        step(0, 0);
    endtask

    function automatic int exp_md(input logic [5:0] code, input logic [5:0] slot,
                                  input logic [1:0] g);
        if (code <= 6'h3A) return (code == slot) ? 1 : 0;
        if (code == 6'h3B) return 2;
        return (code - 6'h3C == {4'd0, g}) ? 3 : 0;
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        step(1, 0); step(1, 0);
        check("R1 sel_n in reset", sel_n, 1);
        check("R1 tdo_oe in reset", tdo_oe, 0);
        rst = 1'b0;
        step(0, 0);
        check("R1 sel_n after reset", sel_n, 1);
        check("R1 en_n after reset", en_n, 1);

        // single claim with upper bits set
        slot_addr = 6'd5;
        scan_ir(8'hC5);
        check("R2 sel_n single", sel_n, 0);
        check("R2 en_n single", en_n, 0);
        scan_ir(8'h03);
        check("R10 oe in Shift-IR", last_oe, 1);
        check("R10 IR capture", last_out, 8'h01);
        scan_dr(2, 8'h02);
        check("R7 group capture after reset", last_out[1:0], 2'b00);
        check("R10 oe in Shift-DR", last_oe, 1);
        scan_dr(2, 8'h01);
        check("R7 group readback", last_out[1:0], 2'b10);
        scan_ir(8'hAA);
        scan_dr(4, 8'h0B);
        check("R11 bypass path", last_out[3:0], 4'b0110);
        scan_ir(8'hC3);
        check("R4 gotowait", sel_n, 1);

        // group 1 is stored now
        scan_ir(8'h3E);
        check("R6 group mismatch", sel_n, 1);
        scan_ir(8'h05);
        check("R3 ignoring holds", sel_n, 1);
        scan_ir(8'hFF);
        check("R12 ir capture while unselected", last_out, 8'h01);
        check("R12 oe low while unselected", last_oe, 0);
        scan_ir(8'hC3);
        scan_ir(8'h3D);
        check("R6 group match", sel_n, 0);
        scan_ir(8'hFF);
        check("R6 no oe in group mode", last_oe, 0);
        scan_ir(8'hC3);
        scan_ir(8'h3B);
        check("R5 broadcast select", sel_n, 0);
        scan_ir(8'hFF);
        check("R5 no oe in broadcast", last_oe, 0);

        lrst_n = 1'b0;
        step(0, 0);
        lrst_n = 1'b1;
        check("R9 local reset", sel_n, 1);
        scan_ir(8'h3D);
        check("R7 group kept over local reset", sel_n, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        check("R8 five tms high", sel_n, 1);
        scan_ir(8'h3C);
        check("R7 group cleared by TLR", sel_n, 0);

        do_rst();
        check("R1 sel_n after mid reset", sel_n, 1);
        slot_addr = 6'h3C;
        scan_ir(8'h3C);
        scan_ir(8'hFF);
        check("R2 reserved slot not single", last_oe, 0);

        for (int it = 0; it < 40; it++) begin
            logic [5:0] s, c;
            logic [1:0] g;
            logic [7:0] code;
            int e, pick;
            s = 6'($urandom % 64);
            g = 2'($urandom % 4);
            pick = $urandom % 3;
            c = (pick == 0) ? s : (pick == 1) ? 6'(59 + $urandom % 5) : 6'($urandom % 64);
            code = {2'($urandom % 4), c};
            slot_addr = s;
            do_rst();
            scan_ir(8'h3B);
            scan_ir(8'h03);
            scan_dr(2, {6'd0, g});
            scan_ir(8'hC3);
            e = exp_md(c, s, g);
            scan_ir(code);
            check("R2 R3 R5 R6 random claim", sel_n, (e == 0));
            scan_ir(8'hFF);
            check("R10 random oe", last_oe, (e == 1));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule